// File: doc/BRIEF.md
# Packed-Frame SPI Master

This block is an SPI master with a small register bus. Software sets a frame length anywhere from 4 to 16 bits, a bit order and a clock divider, then moves data through a single data register. The data register accepts byte-wide or word-wide accesses. Both directions are buffered in byte-wide queues four entries deep. A frame of 8 bits or less takes one byte entry, and a longer frame takes two.

With short frames, the access width sets how many frames move. A word-wide write queues two frames and a word-wide read returns two frames in one word. A byte-wide access moves a single frame. A threshold bit sets when the receive-not-empty flag rises: at one waiting byte or at two. With the bit clear and short frames, a single received frame leaves the flag low. This is the trap that software driving short frames must avoid.

The serial side runs SPI mode 0. The chip select is held low for each frame. Data changes while the clock is low and is sampled on the rising clock edge. The serial clock period is 2^(n+1) system clocks.

Top module: `spi_pack_ctrl`

## Requirements
- R1: After reset, the control register (address 0) reads 0x0038. Its fields are: bit 0 enable, bit 1 LSB-first, bit 2 byte receive threshold, bits 6:3 frame length minus one, bits 9:7 divider exponent. The status register (address 1) reads 0x0001. Its fields are: bit 0 TXE, bit 1 RXNE, bit 2 busy, bit 3 sticky overflow. After reset cs_n is high and sclk is low.
- R2: A control write whose length field is below 3 (lengths 1 to 3) leaves the stored length unchanged. Field values 3 to 15 (lengths 4 to 16) are accepted.
- R3: While enable is set, control writes update only the enable and threshold bits. Length, bit order and divider keep their values.
- R4: Each frame shifts out on mosi MSB-first, or LSB-first when bit 1 is set. cs_n is low for the whole frame. mosi is stable at every rising sclk edge, and miso is sampled on that edge. The sclk period is 2^(n+1) system clocks, where n is the divider exponent.
- R5: RXNE is set when at least one byte is queued with the threshold bit set, and when at least two bytes are queued with it clear.
- R6: With frames of 8 bits or less, a word-wide write to the data register (address 2) queues two frames: bits 7:0 first, then bits 15:8. A byte-wide write queues one frame.
- R7: With frames of 8 bits or less, a word-wide data read returns the older frame in bits 7:0 and the newer frame in bits 15:8. A byte-wide read returns one frame in bits 7:0.
- R8: With frames longer than 8 bits, each data access carries one right-aligned frame. Written bits above the frame length are discarded, and read bits above it are zero.
- R9: TXE is set exactly when at least two of the four transmit byte entries are free.
- R10: A data write that needs more free transmit entries than remain is dropped entirely and sets the overflow bit. The overflow bit stays set until reset.
- R11: A data read with nothing queued returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = word-wide access, 0 = byte-wide access |
| bus_addr | input | 2 | 0 control, 1 status, 2 data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid during the access cycle |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest state to reach is a full transmit queue, because the shifter drains the queue as fast as the bus fills it. The bench therefore programs the configuration with enable cleared and fills the queue with two word-wide writes. It then watches TXE fall, makes a third write that must be dropped, and enables the block to confirm that only the first four frames come back. A second hard case is a single short frame sitting in the receive queue with the threshold bit clear. The bench reaches it by sending one byte-wide frame over a mosi-to-miso loopback, and it then sets the threshold bit while the block is enabled to see RXNE rise.

// File: rtl/spi_pack_pkg.sv
package spi_pack_pkg;

    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;
    localparam int LEN_W  = $clog2(DATA_W);
    localparam int DIV_W  = 3;

    // Control register layout, MSB first: divider, length-1, threshold, order, enable
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [LEN_W-1:0] len_m1;
        logic             rx_byte_thr;
        logic             lsb_first;
        logic             enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{div: '0, len_m1: LEN_W'(7), rx_byte_thr: 1'b0,
                                   lsb_first: 1'b0, enable: 1'b0};

    localparam logic [LEN_W-1:0] LEN_M1_MIN = LEN_W'(3);

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_STAT = 2'd1,
        A_DATA = 2'd2
    } addr_e;

    function automatic logic [DATA_W-1:0] frame_mask(input logic [LEN_W-1:0] len_m1);
        return {DATA_W{1'b1}} >> (LEN_W'(DATA_W - 1) - len_m1);
    endfunction

    function automatic logic is_short(input logic [LEN_W-1:0] len_m1);
        return len_m1 < LEN_W'(BYTE_W);
    endfunction

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    push_n,
    input  logic [W-1:0]  push_d0,
    input  logic [W-1:0]  push_d1,
    input  logic [1:0]    pop_n,
    output logic [CW-1:0] count,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1
);
    // Caller keeps push within free space and pop within count.
    // DEPTH is a power of two so pointers wrap naturally.
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_n != 2'd0) mem[wr_ptr] <= push_d0;
            if (push_n == 2'd2) mem[AW'(wr_ptr + 1'b1)] <= push_d1;
            wr_ptr <= wr_ptr + AW'(push_n);
            rd_ptr <= rd_ptr + AW'(pop_n);
            cnt_q  <= cnt_q + CW'(push_n) - CW'(pop_n);
        end
    end

    assign count = cnt_q;
    assign head0 = mem[rd_ptr];
    assign head1 = mem[AW'(rd_ptr + 1'b1)];

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_frame,
    input  logic [LEN_W-1:0]  len_m1,
    input  logic              lsb_first,
    input  logic [DIV_W-1:0]  div,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_frame,
    output logic              sclk,
    output logic              mosi,
    output logic              cs_n
);
    localparam int DC_W = (1 << DIV_W);

    logic              busy_q, done_q, sclk_q, lsb_q;
    logic [LEN_W-1:0]  k_q, len_q, bit_pos;
    logic [DIV_W-1:0]  div_q;
    logic [DC_W-1:0]   dcnt_q, dlim;
    logic [DATA_W-1:0] txw_q, rxw_q;

    assign dlim    = (DC_W'(1) << div_q) - DC_W'(1);
    assign bit_pos = lsb_q ? k_q : (len_q - k_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            sclk_q <= 1'b0;
            lsb_q  <= 1'b0;
            k_q    <= '0;
            len_q  <= '0;
            div_q  <= '0;
            dcnt_q <= '0;
            txw_q  <= '0;
            rxw_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    txw_q  <= tx_frame;
                    rxw_q  <= '0;
                    len_q  <= len_m1;
                    lsb_q  <= lsb_first;
                    div_q  <= div;
                    k_q    <= '0;
                    dcnt_q <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (dcnt_q == dlim) begin
                dcnt_q <= '0;
                if (!sclk_q) begin
                    sclk_q         <= 1'b1;
                    rxw_q[bit_pos] <= miso;
                end else begin
                    sclk_q <= 1'b0;
                    if (k_q == len_q) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        k_q <= k_q + 1'b1;
                    end
                end
            end else begin
                dcnt_q <= dcnt_q + 1'b1;
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign rx_frame = rxw_q;
    assign sclk     = sclk_q;
    assign mosi     = busy_q ? txw_q[bit_pos] : 1'b0;
    assign cs_n     = !busy_q;

endmodule

// File: rtl/spi_pack_ctrl.sv
module spi_pack_ctrl
    import spi_pack_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic        bus_wide,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);
    ctrl_t ctrl_q, ctrl_wr;
    logic  ovf_q, two_q;

    logic              short_fr;
    logic [DATA_W-1:0] mask;
    logic              wr_ctrl, wr_data, rd_data;
    logic [1:0]        w_need, r_want, fr_bytes;
    logic              w_fits;

    logic [CW-1:0]     tx_cnt, rx_cnt, tx_free, rx_free;
    logic [BYTE_W-1:0] tx_h0, tx_h1, rx_h0, rx_h1;
    logic [1:0]        tx_push, tx_pop, rx_push, rx_pop;
    logic [BYTE_W-1:0] tx_d0, tx_d1;

    logic              eng_start, eng_busy, eng_done;
    logic [DATA_W-1:0] eng_tx, eng_rx;

    logic              st_txe, st_rxne, st_busy;

    assign short_fr = is_short(ctrl_q.len_m1);
    assign mask     = frame_mask(ctrl_q.len_m1);

    assign wr_ctrl = bus_en && bus_we && (bus_addr == A_CTRL);
    assign wr_data = bus_en && bus_we && (bus_addr == A_DATA);
    assign rd_data = bus_en && !bus_we && (bus_addr == A_DATA);

    assign fr_bytes = short_fr ? 2'd1 : 2'd2;
    assign w_need   = (short_fr && !bus_wide) ? 2'd1 : 2'd2;
    assign r_want   = w_need;

    assign tx_free = CW'(FIFO_DEPTH) - tx_cnt;
    assign rx_free = CW'(FIFO_DEPTH) - rx_cnt;
    assign w_fits  = tx_free >= CW'(w_need);

    // transmit side: bytes masked to the frame length on entry
    assign tx_push = (wr_data && w_fits) ? w_need : 2'd0;
    assign tx_d0   = bus_wdata[7:0] & mask[7:0];
    assign tx_d1   = bus_wdata[15:8] & (short_fr ? mask[7:0] : mask[15:8]);

    assign eng_start = ctrl_q.enable && !eng_busy && !eng_done
                     && (tx_cnt >= CW'(fr_bytes)) && (rx_free >= CW'(fr_bytes));
    assign tx_pop    = eng_start ? fr_bytes : 2'd0;
    assign eng_tx    = short_fr ? {8'h00, tx_h0} : {tx_h1, tx_h0};

    // receive side
    assign rx_push = eng_done ? (two_q ? 2'd2 : 2'd1) : 2'd0;
    always_comb begin
        rx_pop = 2'd0;
        if (rd_data) rx_pop = (rx_cnt >= CW'(r_want)) ? r_want : 2'(rx_cnt);
    end

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) tx_fifo_i (
        .clk(clk), .rst(rst),
        .push_n(tx_push), .push_d0(tx_d0), .push_d1(tx_d1),
        .pop_n(tx_pop), .count(tx_cnt), .head0(tx_h0), .head1(tx_h1)
    );

    spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) rx_fifo_i (
        .clk(clk), .rst(rst),
        .push_n(rx_push), .push_d0(eng_rx[7:0]), .push_d1(eng_rx[15:8]),
        .pop_n(rx_pop), .count(rx_cnt), .head0(rx_h0), .head1(rx_h1)
    );

    spi_shift_engine eng_i (
        .clk(clk), .rst(rst), .start(eng_start), .tx_frame(eng_tx),
        .len_m1(ctrl_q.len_m1), .lsb_first(ctrl_q.lsb_first), .div(ctrl_q.div),
        .miso(miso), .busy(eng_busy), .done(eng_done), .rx_frame(eng_rx),
        .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
    );

    // control register update with lock and length range filtering
    always_comb begin
        ctrl_t req;
        req     = ctrl_t'(bus_wdata[CTRL_W-1:0]);
        ctrl_wr = ctrl_q;
        ctrl_wr.enable      = req.enable;
        ctrl_wr.rx_byte_thr = req.rx_byte_thr;
        if (!ctrl_q.enable) begin
            ctrl_wr.lsb_first = req.lsb_first;
            ctrl_wr.div       = req.div;
            if (req.len_m1 >= LEN_M1_MIN) ctrl_wr.len_m1 = req.len_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            ovf_q  <= 1'b0;
            two_q  <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_wr;
            if (wr_data && !w_fits) ovf_q <= 1'b1;
            if (eng_start) two_q <= !short_fr;
        end
    end

    assign st_txe  = tx_free >= CW'(2);
    assign st_rxne = ctrl_q.rx_byte_thr ? (rx_cnt >= CW'(1)) : (rx_cnt >= CW'(2));
    assign st_busy = eng_busy || (tx_cnt != '0);

    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_we) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata = 16'(ctrl_q);
                A_STAT:  bus_rdata = {12'h000, ovf_q, st_busy, st_rxne, st_txe};
                A_DATA: begin
                    bus_rdata[7:0]  = (rx_cnt >= CW'(1)) ? rx_h0 : 8'h00;
                    bus_rdata[15:8] = (r_want == 2'd2 && rx_cnt >= CW'(2)) ? rx_h1 : 8'h00;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_pack_chk.sv
module spi_pack_chk
    import spi_pack_pkg::*;
#(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input ctrl_t         ctrl,
    input logic [CW-1:0] rx_cnt,
    input logic          rxne,
    input logic          ovf,
    input logic          sclk,
    input logic          mosi,
    input logic          cs_n
);
    p_len_legal_r2: assert property (@(posedge clk) disable iff (rst)
        ctrl.len_m1 >= LEN_M1_MIN);

    p_cfg_lock_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl.enable |=> ($stable(ctrl.len_m1) && $stable(ctrl.lsb_first) && $stable(ctrl.div)));

    p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sclk);

    p_mosi_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && $rose(sclk)) |-> $stable(mosi));

    p_rxne_level_r5: assert property (@(posedge clk) disable iff (rst)
        rxne |-> (rx_cnt >= (ctrl.rx_byte_thr ? CW'(1) : CW'(2))));

    p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);
endmodule

bind spi_pack_ctrl spi_pack_chk #(.CW(CW)) chk_i (
    .clk(clk), .rst(rst), .ctrl(ctrl_q), .rx_cnt(rx_cnt), .rxne(st_rxne),
    .ovf(ovf_q), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/spi_pack_ctrl_tb.sv
`timescale 1ns/1ps
module spi_pack_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        sclk, cs_n;
    wire         loop_w;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    spi_pack_ctrl dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(loop_w), .miso(loop_w), .cs_n(cs_n)
    );

    // serial monitor: bit seen at each rising sclk while selected
    logic cap [64];
    int   capn = 0;
    time  tr0, tr1;
    always @(posedge sclk) begin
        if (!cs_n) begin
            if (capn == 0) tr0 = $time;
            if (capn == 1) tr1 = $time;
            if (capn < 64) cap[capn] = loop_w;
            capn++;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [1:0] a, input logic wide, input logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic brd(input logic [1:0] a, input logic wide, output logic [15:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_wide = wide; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 2000; i++) begin
            brd(2'd1, 1'b1, s);
            if (s[2] == 1'b0) break;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic set_cfg(input int len, input logic lsb, input logic thr, input int dv);
        logic [15:0] cw;
        cw = {6'b0, 3'(dv), 4'(len - 1), thr, lsb, 1'b0};
        bwr(2'd0, 1'b1, 16'h0000);
        bwr(2'd0, 1'b1, cw);
        bwr(2'd0, 1'b1, cw | 16'h0001);
    endtask

    function automatic int serial_mism(input int base, input int len, input logic lsb,
                                       input logic [15:0] v);
        int m = 0;
        for (int i = 0; i < len; i++) begin
            if (cap[base + i] !== (lsb ? v[i] : v[len - 1 - i])) m++;
        end
        return m;
    endfunction

    initial begin
        #1_000_000;
        nerr++;
        nchk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 cs_n idle", {15'b0, cs_n}, 16'h1);
        chk("R1 sclk idle", {15'b0, sclk}, 16'h0);
        brd(2'd0, 1'b1, r); chk("R1 ctrl reset", r, 16'h0038);
        brd(2'd1, 1'b1, r); chk("R1 status reset", r, 16'h0001);

        // R11 empty read
        brd(2'd2, 1'b1, r); chk("R11 empty read", r, 16'h0000);

        // R2 length range
        bwr(2'd0, 1'b1, 16'h0010);
        brd(2'd0, 1'b1, r); chk("R2 length 3 rejected", r, 16'h0038);
        bwr(2'd0, 1'b1, 16'h0018);
        brd(2'd0, 1'b1, r); chk("R2 length 4 accepted", r, 16'h0018);
        bwr(2'd0, 1'b1, 16'h0038);

        // R3 lock while enabled
        set_cfg(8, 1'b0, 1'b0, 0);
        bwr(2'd0, 1'b1, 16'h02DB);
        brd(2'd0, 1'b1, r); chk("R3 fields locked", r, 16'h0039);
        bwr(2'd0, 1'b1, 16'h02DF);
        brd(2'd0, 1'b1, r); chk("R3 threshold still writable", r, 16'h003D);

        // R5 threshold behaviour, R7 byte read
        set_cfg(8, 1'b0, 1'b0, 0);
        bwr(2'd2, 1'b0, 16'h005A);
        wait_idle();
        brd(2'd1, 1'b1, r); chk("R5 one byte, threshold clear", {15'b0, r[1]}, 16'h0);
        bwr(2'd2, 1'b0, 16'h00C3);
        wait_idle();
        brd(2'd1, 1'b1, r); chk("R5 two bytes, threshold clear", {15'b0, r[1]}, 16'h1);
        brd(2'd2, 1'b0, r); chk("R7 byte read one frame", r, 16'h005A);
        brd(2'd1, 1'b1, r); chk("R5 one byte left, threshold clear", {15'b0, r[1]}, 16'h0);
        bwr(2'd0, 1'b1, 16'h003D);
        brd(2'd1, 1'b1, r); chk("R5 one byte, threshold set", {15'b0, r[1]}, 16'h1);
        brd(2'd2, 1'b0, r); chk("R7 byte read second frame", r, 16'h00C3);
        brd(2'd1, 1'b1, r); chk("R5 empty, threshold set", {15'b0, r[1]}, 16'h0);
        set_cfg(12, 1'b0, 1'b0, 0);
        bwr(2'd2, 1'b1, 16'hFABC);
        wait_idle();
        brd(2'd1, 1'b1, r); chk("R5 long frame, threshold clear", {15'b0, r[1]}, 16'h1);
        brd(2'd2, 1'b1, r); chk("R8 long frame masked", r, 16'h0ABC);

        // sweep of every length and both bit orders (R4 R6 R7 R8)
        for (int len = 4; len <= 16; len++) begin
            for (int lsb = 0; lsb < 2; lsb++) begin
                logic [15:0] w, e, m16;
                logic [7:0]  m8;
                set_cfg(len, 1'(lsb), 1'b1, 0);
                w   = 16'(len * 16'h1357 + lsb * 16'h0F0F + 16'h2468);
                m16 = 16'((32'd1 << len) - 1);
                m8  = m16[7:0];
                capn = 0;
                bwr(2'd2, 1'b1, w);
                wait_idle();
                brd(2'd2, 1'b1, r);
                if (len <= 8) begin
                    e = {w[15:8] & m8, w[7:0] & m8};
                    chk($sformatf("R6 R7 packed pair len=%0d", len), r, e);
                    chk($sformatf("R4 bit count len=%0d", len), 16'(capn), 16'(2 * len));
                    chk($sformatf("R4 order len=%0d lsb=%0d", len, lsb),
                        16'(serial_mism(0, len, 1'(lsb), {8'h0, e[7:0]})
                          + serial_mism(len, len, 1'(lsb), {8'h0, e[15:8]})), 16'h0);
                end else begin
                    e = w & m16;
                    chk($sformatf("R8 right-aligned len=%0d", len), r, e);
                    chk($sformatf("R4 bit count len=%0d", len), 16'(capn), 16'(len));
                    chk($sformatf("R4 order len=%0d lsb=%0d", len, lsb),
                        16'(serial_mism(0, len, 1'(lsb), e)), 16'h0);
                end
            end
        end

        // R4 clock divider: exponent 2 gives an 8-cycle (80 ns) period
        set_cfg(8, 1'b0, 1'b1, 2);
        capn = 0;
        bwr(2'd2, 1'b0, 16'h0096);
        wait_idle();
        chk("R4 sclk period", 16'(tr1 - tr0), 16'd80);
        chk("R4 bit count divided", 16'(capn), 16'd8);
        brd(2'd2, 1'b0, r); chk("R4 divided loopback", r, 16'h0096);

        // R9 R10 fill with the shifter disabled
        bwr(2'd0, 1'b1, 16'h0000);
        bwr(2'd0, 1'b1, 16'h003C);
        bwr(2'd2, 1'b1, 16'h2211);
        brd(2'd1, 1'b1, r); chk("R9 two free entries", r, 16'h0005);
        bwr(2'd2, 1'b1, 16'h4433);
        brd(2'd1, 1'b1, r); chk("R9 queue full", r, 16'h0004);
        bwr(2'd2, 1'b1, 16'h6655);
        brd(2'd1, 1'b1, r); chk("R10 overflow set", r, 16'h000C);
        bwr(2'd0, 1'b1, 16'h003D);
        wait_idle();
        brd(2'd2, 1'b1, r); chk("R10 first pair kept", r, 16'h2211);
        brd(2'd2, 1'b1, r); chk("R10 second pair kept", r, 16'h4433);
        brd(2'd2, 1'b1, r); chk("R10 R11 dropped write absent", r, 16'h0000);
        brd(2'd1, 1'b1, r); chk("R10 overflow sticky", r, 16'h0009);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule